// File: doc/BRIEF.md
# Time Slot Interchanger

This block moves 8-bit channel samples between time slots of a serial TDM frame. A frame carries N = 2^SLOT_BITS slots of eight bits each, one bit per clock. A pulse on the input frame strobe marks the first bit of slot 0. Bits enter most significant first and are gathered into bytes. Each byte is stored at the index of the slot it arrived in. For every output slot, a per-slot routing table names the input slot to play back. That byte is then shifted out serially, again most significant bit first.

There are two sample banks. One bank fills while the other drains, and the two swap at every frame boundary. So a sample from input frame F always leaves during output frame F+1, and the output frame lines up bit-for-bit with the input frame. Routing entries are written through a simple write port into a pending copy. The pending copy becomes active only at a frame boundary, so a single output frame never mixes two routings.

Top module: `tsi_switch`

## Requirements
- R1: While reset is held and in the first cycle after it, tx_bit and tx_fsync are 0.
- R2: A frame is N*8 clock cycles long. rx_fsync high marks slot 0, bit 0, and framing continues at that period with no further pulses.
- R3: Serial data is most significant bit first on both rx_bit and tx_bit. Bit b of a slot (b = 0..7) carries sample bit 7-b.
- R4: After reset the routing is the identity: output slot j of frame F+1 carries input slot j of frame F.
- R5: tx_fsync is high exactly in the cycle that carries bit 0 of output slot 0, which is N*8 cycles after the rx_fsync of the frame being played back. It is low in every other cycle.
- R6: With routing entry j set to s, output slot j carries input slot s of the previous frame. Any many-to-one pattern (broadcast) is allowed.
- R7: A routing write (cfg_we, cfg_out_slot = j, cfg_in_slot = s) made in any cycle except the last of an input frame governs the output frame that begins right after that input frame. A write in the last cycle applies one frame later. The output frame in progress when the write is made is never affected.
- R8: Routing output slot 0 from input slot N-1 delivers the byte completed in the very last cycle of the previous input frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one serial bit per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_fsync | input | 1 | Input frame strobe, high on bit 0 of slot 0 |
| rx_bit | input | 1 | Serial input data |
| cfg_we | input | 1 | Routing table write strobe |
| cfg_out_slot | input | SLOT_BITS | Output slot whose routing entry is written |
| cfg_in_slot | input | SLOT_BITS | Input slot that output slot will carry |
| tx_fsync | output | 1 | Output frame strobe, high on bit 0 of output slot 0 |
| tx_bit | output | 1 | Serial output data |

## Verification
The bench builds the block with SLOT_BITS = 3, which gives eight slots and a 64-cycle frame. That makes every slot, including the wrap from the last slot to slot 0, reachable within a few frames. Reversal and broadcast routings run across back-to-back frames. Routing writes are placed both mid-frame and in the final cycle of a frame, to separate the two update points. The reversed map also routes the last input slot to output slot 0, which exercises the same-cycle hand-off at the bank swap.

// File: rtl/tsi_pkg.sv
package tsi_pkg;
  localparam int SAMPLE_W  = 8;
  localparam int BIT_IDX_W = $clog2(SAMPLE_W);

  typedef logic [SAMPLE_W-1:0] sample_t;

  // Serial bits arrive MSB first: each new bit enters at the LSB end.
  function automatic sample_t shift_in(sample_t acc, logic b);
    return {acc[SAMPLE_W-2:0], b};
  endfunction

  // Next outgoing byte state after one bit has left from the MSB end.
  function automatic sample_t shift_out(sample_t acc);
    return {acc[SAMPLE_W-2:0], 1'b0};
  endfunction
endpackage

// File: rtl/tsi_frame_timer.sv
module tsi_frame_timer
  import tsi_pkg::*;
#(
  parameter int SLOT_BITS = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sync,
  output logic [SLOT_BITS-1:0] slot_idx,
  output logic [BIT_IDX_W-1:0] bit_idx,
  output logic                 slot_end,
  output logic                 frame_end
);
  localparam int POS_W = SLOT_BITS + BIT_IDX_W;

  logic [POS_W-1:0] pos_q;
  logic [POS_W-1:0] pos_cur;

  // The strobe forces the current cycle to frame position zero.
  assign pos_cur   = sync ? '0 : pos_q;
  assign slot_idx  = pos_cur[POS_W-1:BIT_IDX_W];
  assign bit_idx   = pos_cur[BIT_IDX_W-1:0];
  assign slot_end  = (bit_idx == BIT_IDX_W'(SAMPLE_W-1));
  assign frame_end = &pos_cur;

  always_ff @(posedge clk) begin
    if (!rst_n) pos_q <= '0;
    else        pos_q <= pos_cur + 1'b1;
  end
endmodule

// File: rtl/tsi_ctl_map.sv
module tsi_ctl_map #(
  parameter int SLOT_BITS = 5
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic [SLOT_BITS-1:0]           wr_slot,
  input  logic [SLOT_BITS-1:0]           wr_src,
  input  logic                           swap,
  input  logic [SLOT_BITS-1:0]           rd_slot,
  input  logic                           rd_pend,
  output logic [SLOT_BITS-1:0]           rd_src,
  output logic [(1<<SLOT_BITS)*SLOT_BITS-1:0] act_flat
);
  localparam int NSLOT = 1 << SLOT_BITS;

  logic [SLOT_BITS-1:0] act  [NSLOT];
  logic [SLOT_BITS-1:0] pend [NSLOT];

  for (genvar gi = 0; gi < NSLOT; gi++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        act[gi]  <= SLOT_BITS'(gi);
        pend[gi] <= SLOT_BITS'(gi);
      end else begin
        if (wr_en && wr_slot == SLOT_BITS'(gi)) pend[gi] <= wr_src;
        if (swap) act[gi] <= pend[gi];
      end
    end
    assign act_flat[gi*SLOT_BITS +: SLOT_BITS] = act[gi];
  end

  // At the boundary the first slot of the new frame already follows pending.
  assign rd_src = rd_pend ? pend[rd_slot] : act[rd_slot];
endmodule

// File: rtl/tsi_data_bank.sv
module tsi_data_bank
  import tsi_pkg::*;
#(
  parameter int SLOT_BITS = 5
) (
  input  logic                 clk,
  input  logic                 wr_en,
  input  logic                 wr_bank,
  input  logic [SLOT_BITS-1:0] wr_addr,
  input  sample_t              wr_data,
  input  logic                 rd_bank,
  input  logic [SLOT_BITS-1:0] rd_addr,
  output sample_t              rd_data
);
  localparam int NSLOT = 1 << SLOT_BITS;
  localparam int NBANK = 2;

  sample_t mem [NBANK][NSLOT];

  for (genvar gb = 0; gb < NBANK; gb++) begin : g_bank
    for (genvar gw = 0; gw < NSLOT; gw++) begin : g_word
      always_ff @(posedge clk) begin
        if (wr_en && wr_bank == 1'(gb) && wr_addr == SLOT_BITS'(gw))
          mem[gb][gw] <= wr_data;
      end
    end
  end

  assign rd_data = mem[rd_bank][rd_addr];
endmodule

// File: rtl/tsi_switch.sv
module tsi_switch
  import tsi_pkg::*;
#(
  parameter int SLOT_BITS = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rx_fsync,
  input  logic                 rx_bit,
  input  logic                 cfg_we,
  input  logic [SLOT_BITS-1:0] cfg_out_slot,
  input  logic [SLOT_BITS-1:0] cfg_in_slot,
  output logic                 tx_fsync,
  output logic                 tx_bit
);
  localparam int NSLOT  = 1 << SLOT_BITS;
  localparam int MAP_W  = NSLOT * SLOT_BITS;

  // Named internal events, also used by the bound checker.
  logic [SLOT_BITS-1:0] slot_idx;
  logic [BIT_IDX_W-1:0] bit_idx;
  logic                 slot_end;
  logic                 frame_end;
  logic                 wr_bank_q;
  logic [MAP_W-1:0]     act_map_flat;

  logic [SLOT_BITS-1:0] next_slot;
  logic [SLOT_BITS-1:0] src_slot;
  logic                 rd_bank;
  logic                 fwd_hit;
  sample_t              in_shift_q;
  sample_t              in_byte;
  sample_t              rd_byte;
  sample_t              load_byte;
  sample_t              out_shift_q;
  logic                 tx_fsync_q;

  tsi_frame_timer #(.SLOT_BITS(SLOT_BITS)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .sync      (rx_fsync),
    .slot_idx  (slot_idx),
    .bit_idx   (bit_idx),
    .slot_end  (slot_end),
    .frame_end (frame_end)
  );

  assign in_byte   = shift_in(in_shift_q, rx_bit);
  assign next_slot = SLOT_BITS'(slot_idx + 1'b1);

  tsi_ctl_map #(.SLOT_BITS(SLOT_BITS)) u_map (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (cfg_we),
    .wr_slot  (cfg_out_slot),
    .wr_src   (cfg_in_slot),
    .swap     (frame_end),
    .rd_slot  (next_slot),
    .rd_pend  (frame_end),
    .rd_src   (src_slot),
    .act_flat (act_map_flat)
  );

  // At the frame boundary the bank being filled becomes the playback bank.
  assign rd_bank = frame_end ? wr_bank_q : ~wr_bank_q;

  tsi_data_bank #(.SLOT_BITS(SLOT_BITS)) u_bank (
    .clk     (clk),
    .wr_en   (slot_end),
    .wr_bank (wr_bank_q),
    .wr_addr (slot_idx),
    .wr_data (in_byte),
    .rd_bank (rd_bank),
    .rd_addr (src_slot),
    .rd_data (rd_byte)
  );

  // The last input byte is written in the same cycle it may be needed.
  assign fwd_hit   = frame_end && (src_slot == slot_idx);
  assign load_byte = fwd_hit ? in_byte : rd_byte;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_shift_q  <= '0;
      out_shift_q <= '0;
      wr_bank_q   <= 1'b0;
      tx_fsync_q  <= 1'b0;
    end else begin
      in_shift_q  <= in_byte;
      out_shift_q <= slot_end ? load_byte : shift_out(out_shift_q);
      tx_fsync_q  <= frame_end;
      if (frame_end) wr_bank_q <= ~wr_bank_q;
    end
  end

  assign tx_bit   = out_shift_q[SAMPLE_W-1];
  assign tx_fsync = tx_fsync_q;
endmodule

// File: rtl/tsi_switch_chk.sv
module tsi_switch_chk
  import tsi_pkg::*;
#(
  parameter int SLOT_BITS = 5
) (
  input logic                                  clk,
  input logic                                  rst_n,
  input logic                                  rx_fsync,
  input logic                                  tx_fsync,
  input logic [SLOT_BITS-1:0]                  slot_idx,
  input logic [BIT_IDX_W-1:0]                  bit_idx,
  input logic                                  frame_end,
  input logic                                  bank_sel,
  input logic [(1<<SLOT_BITS)*SLOT_BITS-1:0]   act_map
);
  // R2: after the last position the count restarts at slot 0, bit 0
  a_r2_frame_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> (rx_fsync || (slot_idx == '0 && bit_idx == '0)));

  // R5: output strobe follows each input frame end by one cycle
  a_r5_tx_sync_follows: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> tx_fsync);

  // R5: no output strobe anywhere else
  a_r5_tx_sync_only: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_end |=> !tx_fsync);

  // R8: banks exchange roles at every boundary
  a_r8_bank_swap: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> (bank_sel != $past(bank_sel)));

  // R8: banks keep their roles inside a frame
  a_r8_bank_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_end |=> $stable(bank_sel));

  // R7: the active routing changes only at a frame boundary
  a_r7_map_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_end |=> $stable(act_map));
endmodule

bind tsi_switch tsi_switch_chk #(.SLOT_BITS(SLOT_BITS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rx_fsync  (rx_fsync),
  .tx_fsync  (tx_fsync),
  .slot_idx  (slot_idx),
  .bit_idx   (bit_idx),
  .frame_end (frame_end),
  .bank_sel  (wr_bank_q),
  .act_map   (act_map_flat)
);

// File: tb/test_tsi_switch.sv
module test_tsi_switch;
  localparam int SB = 3;
  localparam int N  = 1 << SB;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rx_fsync = 1'b0;
  logic          rx_bit = 1'b0;
  logic          cfg_we = 1'b0;
  logic [SB-1:0] cfg_out_slot = '0;
  logic [SB-1:0] cfg_in_slot = '0;
  logic          tx_fsync;
  logic          tx_bit;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  tsi_switch #(.SLOT_BITS(SB)) i_tsi_switch (
    .clk          (clk),
    .rst_n        (rst_n),
    .rx_fsync     (rx_fsync),
    .rx_bit       (rx_bit),
    .cfg_we       (cfg_we),
    .cfg_out_slot (cfg_out_slot),
    .cfg_in_slot  (cfg_in_slot),
    .tx_fsync     (tx_fsync),
    .tx_bit       (tx_bit)
  );

  // Stimulus and model state shared by the scenario tasks.
  logic [7:0]    din   [N];
  logic [7:0]    dout  [N];
  logic [7:0]    prev_in [N];
  logic          cfg_en [N];
  logic [SB-1:0] cfg_val [N];
  logic [SB-1:0] map_out [N];
  logic [SB-1:0] map_pend [N];
  logic [SB-1:0] map_next [N];
  logic          late_en = 1'b0;
  logic [SB-1:0] late_slot = '0;
  logic [SB-1:0] late_val = '0;
  bit            have_prev = 1'b0;
  bit            seen_sync = 1'b0;
  string         tag = "R4";

  task automatic check(string rq, string what, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s: got 0x%0h expected 0x%0h", rq, what, got, exp);
    end
  endtask

  task automatic clear_cfg();
    for (int i = 0; i < N; i++) begin
      cfg_en[i]  = 1'b0;
      cfg_val[i] = '0;
    end
    late_en = 1'b0;
  endtask

  // One frame: drive input, capture the concurrent output frame, compare.
  task automatic run_frame(input bit sync);
    int   fs_first;
    int   fs_other;
    for (int s = 0; s < N; s++) begin
      for (int b = 0; b < 8; b++) begin
        @(negedge clk);
        dout[s][7-b] = tx_bit;
        if (s == 0 && b == 0) fs_first = int'(tx_fsync);
        else if (tx_fsync) fs_other++;
        rx_fsync = sync && s == 0 && b == 0;
        rx_bit   = din[s][7-b];
        cfg_we       = 1'b0;
        cfg_out_slot = '0;
        cfg_in_slot  = '0;
        if (b == 0 && cfg_en[s]) begin
          cfg_we       = 1'b1;
          cfg_out_slot = SB'(s);
          cfg_in_slot  = cfg_val[s];
          map_pend[s]  = cfg_val[s];
        end
        if (s == N-1 && b == 7) begin
          for (int i = 0; i < N; i++) map_next[i] = map_pend[i];
          if (late_en) begin
            cfg_we       = 1'b1;
            cfg_out_slot = late_slot;
            cfg_in_slot  = late_val;
            map_pend[late_slot] = late_val;
          end
        end
      end
    end
    // R5: strobe on bit 0 of output slot 0 once a frame has completed
    check("R5", "tx_fsync at slot 0 bit 0", fs_first, int'(have_prev));
    check("R5", "tx_fsync elsewhere count", fs_other, 0);
    if (have_prev) begin
      for (int j = 0; j < N; j++)
        check(tag, $sformatf("output slot %0d", j), int'(dout[j]),
              int'(prev_in[map_out[j]]));
    end
    for (int i = 0; i < N; i++) begin
      prev_in[i] = din[i];
      map_out[i] = map_next[i];
    end
    have_prev = 1'b1;
  endtask

  task automatic fill(input int seed);
    for (int i = 0; i < N; i++) din[i] = 8'((seed * 37 + i * 29 + 1) ^ (i << 5));
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check("R1", "tx_bit in reset", int'(tx_bit), 0);
    check("R1", "tx_fsync in reset", int'(tx_fsync), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "tx_bit after reset", int'(tx_bit), 0);
    check("R1", "tx_fsync after reset", int'(tx_fsync), 0);
    for (int i = 0; i < N; i++) begin
      map_pend[i] = SB'(i);
      map_out[i]  = SB'(i);
    end
    clear_cfg();
  endtask

  task automatic t_identity();
    // R4 with asymmetric bytes so a bit-order slip (R3) also shows
    tag = "R4/R3";
    fill(1);
    din[0] = 8'h80; din[1] = 8'h01; din[2] = 8'hC3; din[3] = 8'h0E;
    run_frame(1'b1);
    fill(2);
    run_frame(1'b1);
  endtask

  task automatic t_reverse();
    // Writes made during this frame leave the concurrent output alone (R7)
    tag = "R7";
    for (int j = 0; j < N; j++) begin
      cfg_en[j]  = 1'b1;
      cfg_val[j] = SB'(N-1-j);
    end
    fill(3);
    din[N-1] = 8'hA5;
    run_frame(1'b1);
    clear_cfg();
    // R6 reversal; output slot 0 takes the last input slot (R8)
    tag = "R6/R8";
    fill(4);
    run_frame(1'b1);
  endtask

  task automatic t_broadcast();
    tag = "R6";
    for (int j = 0; j < N; j++) begin
      cfg_en[j]  = 1'b1;
      cfg_val[j] = SB'(2);
    end
    fill(5);
    run_frame(1'b1);
    clear_cfg();
    fill(6);
    run_frame(1'b1);
  endtask

  task automatic t_late_write();
    // R7: a write in the last cycle skips one frame before taking effect
    tag = "R7";
    for (int j = 0; j < N; j++) begin
      cfg_en[j]  = 1'b1;
      cfg_val[j] = SB'(j);
    end
    late_en   = 1'b1;
    late_slot = SB'(0);
    late_val  = SB'(5);
    fill(7);
    run_frame(1'b1);
    clear_cfg();
    fill(8);
    run_frame(1'b1);
    fill(9);
    run_frame(1'b1);
    check("R7", "late entry now active", int'(map_out[0]), 5);
  endtask

  task automatic t_free_run();
    // R2: framing holds with no further strobes
    tag = "R2";
    fill(10);
    run_frame(1'b0);
    fill(11);
    run_frame(1'b0);
    fill(12);
    run_frame(1'b1);
  endtask

  initial begin
    clear_cfg();
    for (int i = 0; i < N; i++) begin
      din[i] = '0; dout[i] = '0; prev_in[i] = '0;
      map_out[i] = SB'(i); map_pend[i] = SB'(i); map_next[i] = SB'(i);
    end
    t_reset();
    t_identity();
    t_reverse();
    t_broadcast();
    t_late_write();
    t_free_run();
    @(negedge clk);
    cfg_we   = 1'b0;
    rx_fsync = 1'b0;
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule